// File: doc/BRIEF.md
# Bidirectional Capacitance Timing Sequencer

This block sequences a constant-current capacitance measurement. An external current source charges or discharges the capacitor under test. Two comparators report when the capacitor voltage is above a lower threshold and above an upper threshold. Each measurement has two slopes. The block first times the rising slope between the two thresholds while the source charges. It then reverses the current and times the falling slope between the same thresholds. The reported value is the mean of the two counts. Averaging the up and down slopes cancels errors from a resistor in parallel with the capacitor and from mains pickup. Timing only between thresholds leaves a dead zone at each slope start, which removes the step caused by series resistance.

A cycle begins with a start pulse. If the lower comparator still reads high, the block first discharges the capacitor until it reads low. The range input selects one of five capacitance decades. That choice fixes the current code sent to the analog side and the full-scale interval used for the timeout. The timing tick comes from dividing the system clock. If any active state waits longer than twice the full-scale interval, the block flags an over-range, switches the source off and goes idle.

Top module: `cap_slope_timer`

## Requirements
- R1: After reset, src_en, done, over_range and busy are 0 and result is 0.
- R2: After a start pulse seen in idle, the block discharges (src_en=1, src_dir=0) for as long as the synchronized lower comparator reads 1. It switches to charging (src_dir=1) on the first cycle that this comparator reads 0.
- R3: The charge count is the number of ticks from the rising edge of the synchronized lower comparator to the rising edge of the synchronized upper comparator. Ticks spent in the dead zone before the lower crossing are not counted.
- R4: After the upper rising crossing, the source stays on and src_dir goes to 0. The discharge count is the number of ticks from the falling edge of the synchronized upper comparator to the falling edge of the synchronized lower comparator.
- R5: When the lower falling crossing ends the discharge slope, result becomes floor((charge count + discharge count) / 2). In the same cycle, done is 1 for exactly one cycle and src_en returns to 0.
- R6: range_sel is captured at start. Codes 0, 1, 2 and 3 give cur_code 0, 1, 2 and 3 (0.5 µA, 5 µA, 50 µA, 500 µA). Codes 4 to 7 give cur_code 3 and use the long full scale. All other codes use the short full scale.
- R7: If the block stays in any one active state for 2×FS_SHORT ticks (short ranges) or 2×FS_LONG ticks (long range), over_range is set and src_en and busy drop on that tick. over_range is cleared by the next accepted start.
- R8: Each slope count saturates at 2^CNT_W−1.
- R9: A start pulse while busy has no effect on the running measurement or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| range_sel | input | 3 | Capacitance range, 0 = smallest, 4..7 = largest |
| cmp_lo | input | 1 | Asynchronous lower-threshold comparator |
| cmp_hi | input | 1 | Asynchronous upper-threshold comparator |
| src_en | output | 1 | Current source enable |
| src_dir | output | 1 | 1 = charge, 0 = discharge |
| cur_code | output | 2 | Current magnitude code for the selected range |
| result | output | CNT_W | Averaged slope count |
| done | output | 1 | One-cycle pulse when result updates |
| over_range | output | 1 | Timeout occurred on the last measurement |
| busy | output | 1 | A measurement is in progress |

## Verification
A comparator change driven between clock edges reaches the state register on the third rising edge that follows. Two of those edges are spent in the synchronizer and one in the edge-detect flop. The bench therefore samples the direction output three cycles after each crossing. It expects done and the new result exactly three cycles after the lower input falls on the discharge slope, and checks that done is low one cycle before and one cycle after. With one tick per clock, a timeout lands exactly 2×FS ticks after the active state was entered. The bench checks over_range one cycle before and at that tick. Expected averages are computed from the crossing spacings the bench itself drives, with saturation applied to each slope.

// File: rtl/cap_slope_timer.sv
module cap_slope_timer #(
  parameter int CNT_W    = 20,
  parameter int TICK_DIV = 50,
  parameter int FS_SHORT = 25000,
  parameter int FS_LONG  = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       range_sel,
  input  logic             cmp_lo,
  input  logic             cmp_hi,
  output logic             src_en,
  output logic             src_dir,
  output logic [1:0]       cur_code,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             over_range,
  output logic             busy
);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam int TO_W  = $clog2(2 * FS_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_CWAIT, S_CTIME, S_DWAIT, S_DTIME} st_t;

  st_t st_q, st_d;
  logic [2:0] lo_sh, hi_sh;
  logic [PRE_W-1:0] pre_q;
  logic [TO_W-1:0] to_q, to_lim;
  logic [2:0] rng_q;
  logic [CNT_W-1:0] cnt_q, chg_q, cnt_inc;
  logic [CNT_W:0] sum;
  logic tick, long_q, expire, fin;
  logic lo_s, hi_s, lo_rise, lo_fall, hi_rise, hi_fall;

  assign lo_s    = lo_sh[1];
  assign hi_s    = hi_sh[1];
  assign lo_rise = lo_sh[1] & ~lo_sh[2];
  assign lo_fall = ~lo_sh[1] & lo_sh[2];
  assign hi_rise = hi_sh[1] & ~hi_sh[2];
  assign hi_fall = ~hi_sh[1] & hi_sh[2];

  assign tick     = (pre_q == PRE_W'(TICK_DIV - 1));
  assign long_q   = (rng_q >= 3'd4);
  assign to_lim   = long_q ? TO_W'(2 * FS_LONG) : TO_W'(2 * FS_SHORT);
  assign cur_code = long_q ? 2'd3 : rng_q[1:0];
  assign busy     = (st_q != S_IDLE);
  assign src_en   = busy;
  assign src_dir  = (st_q == S_CWAIT) || (st_q == S_CTIME);
  assign cnt_inc  = (cnt_q == CNT_MAX || !tick) ? cnt_q : cnt_q + 1'b1;
  assign sum      = {1'b0, chg_q} + {1'b0, cnt_inc};
  assign expire   = busy && tick && (to_q == to_lim - TO_W'(1));
  assign fin      = (st_q == S_DTIME) && lo_fall && !expire;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start)   st_d = S_PRE;
      S_PRE:   if (!lo_s)   st_d = S_CWAIT;
      S_CWAIT: if (lo_rise) st_d = S_CTIME;
      S_CTIME: if (hi_rise) st_d = S_DWAIT;
      S_DWAIT: if (hi_fall) st_d = S_DTIME;
      S_DTIME: if (lo_fall) st_d = S_IDLE;
      default:              st_d = S_IDLE;
    endcase
    if (expire) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      lo_sh      <= '0;
      hi_sh      <= '0;
      pre_q      <= '0;
      to_q       <= '0;
      rng_q      <= '0;
      cnt_q      <= '0;
      chg_q      <= '0;
      result     <= '0;
      done       <= 1'b0;
      over_range <= 1'b0;
    end else begin
      st_q  <= st_d;
      lo_sh <= {lo_sh[1:0], cmp_lo};
      hi_sh <= {hi_sh[1:0], cmp_hi};
      pre_q <= tick ? '0 : pre_q + 1'b1;

      if (st_q == S_IDLE || st_d != st_q) to_q <= '0;
      else if (tick)                      to_q <= to_q + 1'b1;

      if (st_q == S_IDLE && start) begin
        rng_q      <= range_sel;
        over_range <= 1'b0;
      end
      if (expire) over_range <= 1'b1;

      if (st_q == S_CTIME || st_q == S_DTIME) cnt_q <= cnt_inc;
      else                                    cnt_q <= '0;
      if (st_q == S_CTIME && hi_rise) chg_q <= cnt_inc;

      done <= fin;
      if (fin) result <= sum[CNT_W:1];
    end
  end

  p_pre_discharge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PRE) |-> (src_en && !src_dir));

  p_reverse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CTIME && hi_rise && !expire) |=> (src_en && !src_dir));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!src_en && !busy));

  p_code_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_code));

  p_timeout_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_range) |-> (!src_en && !busy));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_CTIME || st_q == S_DTIME) && cnt_q == CNT_MAX && st_d == st_q) |=> (cnt_q == CNT_MAX));
endmodule

// File: tb/cap_slope_timer_test.sv
module cap_slope_timer_test;
  localparam int CW = 6, FSS = 40, FSL = 100;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_lo = 1'b0, cmp_hi = 1'b0;
  logic [2:0] range_sel = '0;
  logic src_en, src_dir, done, over_range, busy;
  logic [1:0] cur_code;
  logic [CW-1:0] result;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cap_slope_timer #(.CNT_W(CW), .TICK_DIV(1), .FS_SHORT(FSS), .FS_LONG(FSL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .range_sel(range_sel),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .src_en(src_en), .src_dir(src_dir),
    .cur_code(cur_code), .result(result), .done(done),
    .over_range(over_range), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int n);
    return (n > SAT) ? SAT : n;
  endfunction

  task automatic pulse_start(input int r);
    range_sel = 3'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic measure(input int r, input int nc, input int nd, input bit poke);
    int expv, code;
    expv = (sat(nc) + sat(nd)) >> 1;
    code = (r >= 4) ? 3 : r;
    @(negedge clk);
    pulse_start(r);
    chk(src_en && !src_dir, "R2 pre-discharge", {src_en, src_dir}, 2);
    chk(!over_range, "R7 cleared by start", over_range, 0);
    @(negedge clk);
    chk(src_en && src_dir, "R2 charge begins", {src_en, src_dir}, 3);
    chk(cur_code == 2'(code), "R6 current code", cur_code, code);
    repeat (3) @(negedge clk);
    cmp_lo = 1'b1;
    repeat (nc) @(negedge clk);
    cmp_hi = 1'b1;
    repeat (4) @(negedge clk);
    chk(src_en && !src_dir, "R4 direction reversed", {src_en, src_dir}, 2);
    if (poke) begin
      pulse_start((r + 1) % 8);
      chk(busy, "R9 busy kept", busy, 1);
    end
    repeat (2) @(negedge clk);
    cmp_hi = 1'b0;
    repeat (nd) @(negedge clk);
    cmp_lo = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done, "R5 done not early", done, 0);
    @(negedge clk);
    chk(done, "R5 done pulse", done, 1);
    chk(result == CW'(expv), poke ? "R9 result unaffected" : "R3 R4 R8 average", result, expv);
    @(negedge clk);
    chk(!done && !src_en && !over_range, "R5 done single, source off", {done, src_en, over_range}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!src_en && !done && !over_range && !busy && result == '0, "R1 reset state",
        {src_en, done, over_range, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!src_en && !busy, "R1 idle after reset", {src_en, busy}, 0);

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 4; i++)
        measure(r, 1 + i * 13 + r, 2 + i * 11 + 2 * r, 1'b0);

    measure(4, 100, 70, 1'b0);
    measure(4, 100, 10, 1'b0);
    measure(7, 70, 100, 1'b0);
    measure(2, 20, 31, 1'b1);

    // R2 and R7: lower comparator held high, then charging wait times out
    cmp_lo = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start(5);
    for (int k = 0; k < 5; k++) begin
      chk(src_en && !src_dir, "R2 discharge while lower high", {src_en, src_dir}, 2);
      @(negedge clk);
    end
    cmp_lo = 1'b0;
    repeat (2) @(negedge clk);
    chk(!src_dir, "R2 still discharging in sync delay", src_dir, 0);
    @(negedge clk);
    chk(src_dir && src_en, "R2 charge after lower low", {src_en, src_dir}, 3);
    chk(cur_code == 2'd3, "R6 range 5 code", cur_code, 3);
    repeat (2 * FSL - 1) @(negedge clk);
    chk(!over_range && src_en, "R7 no early timeout", {over_range, src_en}, 1);
    @(negedge clk);
    chk(over_range && !src_en && !busy, "R7 long timeout", {over_range, src_en, busy}, 4);

    // R7: pre-discharge timeout on a short range
    cmp_lo = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start(0);
    chk(!over_range, "R7 flag cleared on start", over_range, 0);
    repeat (2 * FSS - 1) @(negedge clk);
    chk(!over_range && src_en, "R7 no early timeout short", {over_range, src_en}, 1);
    @(negedge clk);
    chk(over_range && !src_en && !busy, "R7 short timeout", {over_range, src_en, busy}, 4);
    cmp_lo = 1'b0;
    repeat (4) @(negedge clk);
    measure(1, 9, 12, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule